// File: doc/BRIEF.md
# DMA Channel Structure-Select Register Bank

This block holds two per-channel control bits for a multi-channel DMA engine: an enable bit and a structure-select bit that says whether the channel currently works from its primary or its alternate control structure. Software changes both bits through a small register port. Each bit has its own write-one-to-set register and its own write-one-to-clear register, so one channel can be changed without a read-modify-write of the others.

The DMA engine reports the end of each cycle phase as a one-cycle completion event. The event carries the channel number, the cycle mode and the structure that was active. In ping-pong and both scatter-gather modes the bank flips that channel's select bit itself, so the next phase runs from the other structure. Descriptor fetch and data movement are done elsewhere. The bank drives the enable and select vectors to the engine and returns them on reads.

Top module: `dmasel_bank`

## Requirements
- R1: Channels 0 to 20 are implemented. Bits 31:21 of every read return 0. Writes to those bits change nothing, and a completion event whose channel number is 21 or higher is ignored.
- R2: Word address 0 is the enable-set register, 1 is enable-clear, 2 is select-set and 3 is select-clear. Reads at addresses 0 and 1 return the enable vector, and reads at 2 and 3 return the select vector (0 = primary, 1 = alternate). Read data is combinational from the address in the same cycle.
- R3: Writing 1 to bit c at the select-set address makes channel c use the alternate structure from the next cycle on. A 0 bit has no effect.
- R4: Writing 1 to bit c at the select-clear address makes channel c use the primary structure from the next cycle on. A 0 bit has no effect.
- R5: Writing 1 to bit c at the enable-set address enables channel c from the next cycle on. A 0 bit has no effect.
- R6: Writing 1 to bit c at the enable-clear address disables channel c from the next cycle on. A 0 bit has no effect.
- R7: A completion event in ping-pong mode (mode code 3) flips the select bit of its channel one cycle later, whether the active structure was primary or alternate.
- R8: A completion event in memory scatter-gather mode (code 4) or peripheral scatter-gather mode (code 5) flips the select bit of its channel one cycle later. The engine raises one such event when the primary structure's four transfers are done and another when the alternate structure's transfers are done.
- R9: Completion events with mode codes 0 (idle), 1 (basic), 2 (auto-request), 6 or 7 leave every select bit unchanged.
- R10: A completion event whose active-structure tag (0 = primary, 1 = alternate) differs from the channel's current select bit is treated as stale and ignored.
- R11: When a select-set or select-clear write carries a 1 for the same channel that a toggling event names in the same cycle, the write decides the result. A 0 bit in that write lets the toggle happen.
- R12: After reset every channel is disabled and uses the primary structure.
- R13: Completion events never change the enable vector. Only enable-set and enable-clear writes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ev_valid | input | 1 | Completion event strobe |
| ev_chan | input | 5 | Channel number of the event |
| ev_mode | input | 3 | Cycle mode code of the finished phase |
| ev_alt | input | 1 | Structure that was active: 1 = alternate |
| chan_ena | output | 21 | Per-channel enable |
| chan_alt | output | 21 | Per-channel select: 1 = alternate |

## Verification
A wrong select bit shows up on chan_alt and on reads at addresses 2 and 3 in the cycle right after the event or write that caused it. Because every later toggle inverts that bit, the error stays visible until software writes the bit again. The stale-tag rule makes one wrong bit cause more: the next correct event for that channel is then rejected, so the bank and a reference model disagree for as long as the stream lasts. A wrong enable bit cannot come from events at all, so it points straight at the register decode and shows one cycle after the write.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;

  typedef enum logic [1:0] {
    RA_ENA_SET = 2'd0,
    RA_ENA_CLR = 2'd1,
    RA_SEL_SET = 2'd2,
    RA_SEL_CLR = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    MD_IDLE     = 3'd0,
    MD_BASIC    = 3'd1,
    MD_AUTO     = 3'd2,
    MD_PINGPONG = 3'd3,
    MD_MEM_SG   = 3'd4,
    MD_PER_SG   = 3'd5,
    MD_RSV6     = 3'd6,
    MD_RSV7     = 3'd7
  } cyc_mode_e;

  typedef struct packed {
    logic ena_set;
    logic ena_clr;
    logic sel_set;
    logic sel_clr;
  } wr_kind_t;

  // Modes whose phase completion swaps the structure in use
  function automatic logic mode_swaps(input logic [2:0] mode);
    case (mode)
      MD_PINGPONG, MD_MEM_SG, MD_PER_SG: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic wr_kind_t decode_wr(input logic wr, input logic [1:0] addr);
    wr_kind_t k;
    k = '0;
    if (wr) begin
      case (addr)
        RA_ENA_SET: k.ena_set = 1'b1;
        RA_ENA_CLR: k.ena_clr = 1'b1;
        RA_SEL_SET: k.sel_set = 1'b1;
        default:    k.sel_clr = 1'b1;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/dmasel_wdec.sv
module dmasel_wdec
  import dmasel_pkg::*;
#(
  parameter int NCH = 21,
  parameter int DW  = 32
) (
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output wr_kind_t        kind,
  output logic [NCH-1:0]  mask
);
  localparam int RSV = DW - NCH;

  assign kind = decode_wr(wr_en, addr);
  assign mask = wdata[NCH-1:0];

  generate
    if (RSV > 0) begin : g_rsv
      logic unused_rsv_bits;
      assign unused_rsv_bits = ^wdata[DW-1:NCH];
    end
  endgenerate
endmodule

// File: rtl/dmasel_evt.sv
module dmasel_evt
  import dmasel_pkg::*;
#(
  parameter int NCH = 21,
  parameter int CW  = 5
) (
  input  logic            ev_valid,
  input  logic [CW-1:0]   ev_chan,
  input  logic [2:0]      ev_mode,
  input  logic            ev_alt,
  input  logic [NCH-1:0]  sel_cur,
  output logic [NCH-1:0]  tgl_req
);
  logic ev_swaps;
  assign ev_swaps = ev_valid && mode_swaps(ev_mode);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign tgl_req[c] = ev_swaps && (ev_chan == CW'(c)) && (ev_alt == sel_cur[c]);
    end
  endgenerate
endmodule

// File: rtl/dmasel_chan.sv
module dmasel_chan
  import dmasel_pkg::*;
#(
  parameter int NCH = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wr_kind_t        kind,
  input  logic [NCH-1:0]  mask,
  input  logic [NCH-1:0]  tgl_req,
  output logic [NCH-1:0]  ena,
  output logic [NCH-1:0]  sel,
  output logic [NCH-1:0]  tgl_eff
);
  logic [NCH-1:0] sw_sel_hit;
  assign sw_sel_hit = (kind.sel_set || kind.sel_clr) ? mask : '0;
  assign tgl_eff    = tgl_req & ~sw_sel_hit;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_bit
      logic ena_q, sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ena_q <= 1'b0;
          sel_q <= 1'b0;
        end else begin
          if (kind.ena_set && mask[c])      ena_q <= 1'b1;
          else if (kind.ena_clr && mask[c]) ena_q <= 1'b0;
          if (kind.sel_set && mask[c])      sel_q <= 1'b1;
          else if (kind.sel_clr && mask[c]) sel_q <= 1'b0;
          else if (tgl_eff[c])              sel_q <= ~sel_q;
        end
      end
      assign ena[c] = ena_q;
      assign sel[c] = sel_q;
    end
  endgenerate
endmodule

// File: rtl/dmasel_bank.sv
module dmasel_bank
  import dmasel_pkg::*;
#(
  parameter int NCH = 21,
  parameter int DW  = 32,
  parameter int CW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            ev_valid,
  input  logic [CW-1:0]   ev_chan,
  input  logic [2:0]      ev_mode,
  input  logic            ev_alt,
  output logic [NCH-1:0]  chan_ena,
  output logic [NCH-1:0]  chan_alt
);
  localparam int RSV = DW - NCH;

  wr_kind_t       wr_kind;
  logic [NCH-1:0] wr_mask;
  logic [NCH-1:0] tgl_req;
  logic [NCH-1:0] tgl_eff;

  dmasel_wdec #(.NCH(NCH), .DW(DW)) u_wdec (
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .kind  (wr_kind),
    .mask  (wr_mask)
  );

  dmasel_evt #(.NCH(NCH), .CW(CW)) u_evt (
    .ev_valid (ev_valid),
    .ev_chan  (ev_chan),
    .ev_mode  (ev_mode),
    .ev_alt   (ev_alt),
    .sel_cur  (chan_alt),
    .tgl_req  (tgl_req)
  );

  dmasel_chan #(.NCH(NCH)) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (wr_kind),
    .mask    (wr_mask),
    .tgl_req (tgl_req),
    .ena     (chan_ena),
    .sel     (chan_alt),
    .tgl_eff (tgl_eff)
  );

  // Addresses with bit 1 set view the select vector
  assign reg_rdata = {{RSV{1'b0}}, (reg_addr[1] ? chan_alt : chan_ena)};
endmodule

// File: rtl/dmasel_bank_chk.sv
module dmasel_bank_chk #(
  parameter int NCH = 21,
  parameter int DW  = 32,
  parameter int CW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [1:0]      reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic            ev_valid,
  input logic [CW-1:0]   ev_chan,
  input logic [2:0]      ev_mode,
  input logic            ev_alt,
  input logic [NCH-1:0]  chan_ena,
  input logic [NCH-1:0]  chan_alt,
  input logic [NCH-1:0]  tgl_req,
  input logic [NCH-1:0]  tgl_eff
);
  logic sw_sel;
  logic in_range;
  logic swap_mode;
  assign sw_sel    = reg_wr && reg_addr[1];
  assign in_range  = int'(ev_chan) < NCH;
  assign swap_mode = (ev_mode == 3'd3) || (ev_mode == 3'd4) || (ev_mode == 3'd5);

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:NCH] == '0);  // R1
  AST_HIGH_CHAN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !in_range) |-> (tgl_req == '0));  // R1
  AST_SEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=>
      ((chan_alt & $past(reg_wdata[NCH-1:0])) == $past(reg_wdata[NCH-1:0])));  // R3 R11
  AST_SEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> ((chan_alt & $past(reg_wdata[NCH-1:0])) == '0));  // R4 R11
  AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=>
      ((chan_ena & $past(reg_wdata[NCH-1:0])) == $past(reg_wdata[NCH-1:0])));  // R5
  AST_ENA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> ((chan_ena & $past(reg_wdata[NCH-1:0])) == '0));  // R6
  AST_PINGPONG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && in_range && ev_mode == 3'd3 && ev_alt == chan_alt[ev_chan] && !sw_sel) |=>
      (chan_alt[$past(ev_chan)] != $past(chan_alt[ev_chan])));  // R7
  AST_SG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && in_range && (ev_mode == 3'd4 || ev_mode == 3'd5) &&
     ev_alt == chan_alt[ev_chan] && !sw_sel) |=>
      (chan_alt[$past(ev_chan)] != $past(chan_alt[ev_chan])));  // R8
  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgl_eff));  // R7
  AST_OTHER_MODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_sel && !(ev_valid && swap_mode)) |=> $stable(chan_alt));  // R9
  AST_STALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_sel && ev_valid && in_range && ev_alt != chan_alt[ev_chan]) |=> $stable(chan_alt));  // R10
  AST_ENA_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_addr[1]) |=> $stable(chan_ena));  // R13
endmodule

bind dmasel_bank dmasel_bank_chk #(.NCH(NCH), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .ev_valid  (ev_valid),
  .ev_chan   (ev_chan),
  .ev_mode   (ev_mode),
  .ev_alt    (ev_alt),
  .chan_ena  (chan_ena),
  .chan_alt  (chan_alt),
  .tgl_req   (tgl_req),
  .tgl_eff   (tgl_eff)
);

// File: tb/dmasel_bank_test.sv
`timescale 1ns/1ps
module dmasel_bank_test;
  localparam int NCH = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_valid = 1'b0;
  logic [4:0]  ev_chan = '0;
  logic [2:0]  ev_mode = '0;
  logic        ev_alt = 1'b0;
  logic [20:0] chan_ena;
  logic [20:0] chan_alt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R12";

  // Reference state: one entry per channel
  bit ena_m[NCH];
  bit sel_m[NCH];

  always #4 clk = ~clk;

  dmasel_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_chan(ev_chan), .ev_mode(ev_mode), .ev_alt(ev_alt),
    .chan_ena(chan_ena), .chan_alt(chan_alt)
  );

  // Reference model, stated from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin ena_m[c] <= 0; sel_m[c] <= 0; end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit one;
        bit swap;
        one = reg_wdata[c];
        if (reg_wr && reg_addr == 0 && one) ena_m[c] <= 1;
        if (reg_wr && reg_addr == 1 && one) ena_m[c] <= 0;
        swap = ev_valid && int'(ev_chan) == c && ev_mode >= 3 && ev_mode <= 5 && ev_alt == sel_m[c];
        if (reg_wr && reg_addr == 2 && one)      sel_m[c] <= 1;
        else if (reg_wr && reg_addr == 3 && one) sel_m[c] <= 0;
        else if (swap)                           sel_m[c] <= !sel_m[c];
      end
    end
  end

  function automatic logic [20:0] pack_m(input bit which);
    logic [20:0] v;
    for (int c = 0; c < NCH; c++) v[c] = which ? sel_m[c] : ena_m[c];
    return v;
  endfunction

  task automatic compare();
    logic [31:0] exp_rd;
    checks++;
    if (chan_ena !== pack_m(0)) begin
      errors++;
      $display("FAIL %s enable: actual %h expected %h", tag, chan_ena, pack_m(0));
    end
    checks++;
    if (chan_alt !== pack_m(1)) begin
      errors++;
      $display("FAIL %s select: actual %h expected %h", tag, chan_alt, pack_m(1));
    end
    exp_rd = {11'd0, (reg_addr >= 2) ? pack_m(1) : pack_m(0)};
    checks++;
    if (reg_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s/R2 read addr %0d: actual %h expected %h", tag, reg_addr, reg_rdata, exp_rd);
    end
  endtask

  task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d,
                      input bit ev, input logic [4:0] ch, input logic [2:0] md, input bit al);
    @(negedge clk);
    compare();
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    ev_valid = ev; ev_chan = ch; ev_mode = md; ev_alt = al;
  endtask

  task automatic idle(input logic [1:0] a);
    step(0, a, 32'h0, 0, 5'd0, 3'd0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R12"; idle(0); idle(2);
    // R5, R1: set all, including reserved bits
    tag = "R5"; step(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0); idle(0);
    tag = "R6"; step(1, 1, 32'h0015_5555, 0, 0, 0, 0); idle(1);
    step(1, 1, 32'h0, 0, 0, 0, 0); idle(0);
    tag = "R3"; step(1, 2, 32'hFFE0_0F0F, 0, 0, 0, 0); idle(2);
    tag = "R4"; step(1, 3, 32'h0000_0303, 0, 0, 0, 0); idle(3);
    step(1, 2, 32'h0, 0, 0, 0, 0); idle(2);
    // R7 ping-pong on primary then alternate
    tag = "R7"; step(0, 2, 0, 1, 5'd5, 3'd3, 0); idle(2);
    step(0, 2, 0, 1, 5'd5, 3'd3, 1); idle(2);
    step(0, 2, 0, 1, 5'd20, 3'd3, 0); idle(2);
    tag = "R8"; step(0, 2, 0, 1, 5'd6, 3'd4, 0); idle(2);
    step(0, 2, 0, 1, 5'd6, 3'd4, 1); idle(2);
    step(0, 2, 0, 1, 5'd7, 3'd5, 0); idle(3);
    tag = "R9";
    for (int m = 0; m < 8; m++)
      if (m < 3 || m > 5) begin step(0, 2, 0, 1, 5'd9, 3'(m), 0); idle(2); end
    tag = "R10"; step(0, 2, 0, 1, 5'd9, 3'd3, 1); idle(2);
    tag = "R1"; step(0, 2, 0, 1, 5'd21, 3'd3, 0); idle(2);
    step(0, 2, 0, 1, 5'd31, 3'd4, 0); idle(2);
    tag = "R11"; step(1, 2, 32'h0000_0400, 1, 5'd10, 3'd3, 0); idle(2);
    step(1, 3, 32'h0000_0400, 1, 5'd10, 3'd3, 1); idle(2);
    step(1, 2, 32'h0000_0001, 1, 5'd11, 3'd3, 0); idle(2);
    tag = "R13"; step(0, 0, 0, 1, 5'd2, 3'd3, 0); idle(0);
    // Mixed traffic
    tag = "R7/R8/R11 mixed";
    for (int i = 0; i < 4000; i++) begin
      int  ch;
      bit  al;
      ch = $urandom_range(0, 23);
      al = (ch < NCH && $urandom_range(0, 3) != 0) ? sel_m[ch] : 1'($urandom);
      step(($urandom_range(0, 3) == 0), 2'($urandom), $urandom,
           ($urandom_range(0, 2) != 0), 5'(ch), 3'($urandom), al);
    end
    idle(0); idle(2);
    done = 1;
    finish_run();
  end
endmodule